// File: doc/BRIEF.md
# AUX Request Frame Builder

This block turns one request descriptor into the ordered byte sequence of a display auxiliary-channel request and reports how many bytes that sequence holds. A descriptor is a 4-bit command, a 20-bit target address, a transfer length of 0 to 16, a write flag and a start delay. The descriptor is captured on a single-cycle start pulse. The block then waits for the start delay. After that it presents the bytes one at a time on a valid/ready stream and marks the final byte. Line coding, preamble and sync are handled downstream.

The header is three bytes. The first byte packs the command with the top nibble of the address. The next two bytes carry the rest of the address, high byte first. A length byte, holding the length minus one, is added only when the length is nonzero. For a write, the payload follows the header. The payload is fetched from an external buffer through an index output, one byte per accepted transfer. The external buffer must return the addressed byte in the same cycle and must hold its contents steady while a frame is in flight.

The controller is a state machine with these states. IDLE waits for start. WAIT counts down the start delay. HDR0, HDR1 and HDR2 emit the three header bytes. LEN emits the length byte. DATA emits the payload.

The transitions are:
- IDLE to WAIT on start with a nonzero delay.
- IDLE to HDR0 on start with a zero delay.
- WAIT to HDR0 when the delay expires.
- HDR0 to HDR1 and HDR1 to HDR2 on each accepted byte.
- HDR2 to IDLE on an accepted byte when the length is zero.
- HDR2 to LEN on an accepted byte when the length is nonzero.
- LEN to IDLE on an accepted byte for a read.
- LEN to DATA on an accepted byte for a write.
- DATA to IDLE when the final payload byte is accepted.

Top module: `aux_req_framer`

## Requirements
- R1: After reset, out_valid, out_last and busy are 0 and frame_len is 0.
- R2: The first byte of a frame is {cmd[3:0], addr[19:16]}, with the command in bits 7:4.
- R3: The second byte is addr[15:8] and the third byte is addr[7:0].
- R4: With req_len nonzero, a fourth byte equal to req_len-1 follows the address. With req_len zero, the frame ends after the third byte, which carries out_last.
- R5: For a write with nonzero length, req_len payload bytes follow the length byte. Payload byte k is the buffer entry at pay_idx = k, for k from 0 up to req_len-1.
- R6: A read frame never carries payload bytes, whatever its length. A read frame with nonzero length ends on the length byte.
- R7: From the cycle after a start is accepted, frame_len equals (req_len != 0 ? 4 : 3) plus (wr_en ? req_len : 0). It holds that value until the next accepted start.
- R8: A start sampled at a clock edge with start_dly = D raises out_valid after D further edges, so the first byte appears D+1 cycles after the start pulse.
- R9: A start pulse while busy is high is ignored. This includes the cycle in which the final byte is accepted. Such a pulse changes neither the stream nor frame_len, and starts no new frame.
- R10: While out_valid is high and out_ready is low, out_byte and out_last hold their values into the next cycle, and no byte is skipped.
- R11: out_last is high only together with out_valid, and only on the final byte of the frame. busy falls in the cycle after that byte is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to capture the descriptor |
| cmd | input | 4 | Request command nibble |
| addr | input | 20 | Target address |
| req_len | input | 5 | Transfer length, 0 to MAX_LEN |
| wr_en | input | 1 | 1 for a write request, 0 for a read |
| start_dly | input | 8 | Cycles to wait before the first byte |
| pay_idx | output | 4 | Index of the payload byte being requested from the buffer |
| pay_byte | input | 8 | Payload byte at pay_idx, returned in the same cycle |
| out_valid | output | 1 | A frame byte is on out_byte |
| out_ready | input | 1 | Downstream accepts the byte this cycle |
| out_byte | output | 8 | Current frame byte |
| out_last | output | 1 | Current byte is the final byte of the frame |
| frame_len | output | 5 | Total byte count of the current frame |
| busy | output | 1 | A frame is waiting or streaming |

## Verification
Two events can fall in the same cycle: a new start pulse and the acceptance of the final byte of the frame in flight. At that point busy is still high, so the pulse must be dropped. The bench raises start with a different descriptor at exactly the falling edge where the final handshake occurs. One cycle later it judges three things: busy and out_valid must be low, and frame_len must still describe the finished frame. A second case injects a start in the middle of a stalled frame. It confirms that every remaining byte still matches the original descriptor.

// File: rtl/aux_fb_pkg.sv
package aux_fb_pkg;

    localparam int AUX_CMD_W  = 4;
    localparam int AUX_ADDR_W = 20;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_HDR0,
        ST_HDR1,
        ST_HDR2,
        ST_LEN,
        ST_DATA
    } fb_state_e;

endpackage

// File: rtl/aux_fb_delay.sv
module aux_fb_delay #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    input  logic             run,
    output logic             done
);
    logic [DLY_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - DLY_W'(1);
        end
    end

    // Expires on the last counted cycle of the wait
    assign done = run && (cnt_q == DLY_W'(1));

endmodule

// File: rtl/aux_fb_count.sv
module aux_fb_count #(
    parameter int MAX_LEN = 16,
    localparam int LEN_W = $clog2(MAX_LEN + 1),
    localparam int CNT_W = $clog2(MAX_LEN + 5)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] req_len,
    input  logic             wr_en,
    output logic [CNT_W-1:0] frame_len
);
    logic [CNT_W-1:0] hdr_bytes;
    logic [CNT_W-1:0] pay_bytes;

    always_comb begin
        hdr_bytes = (req_len != '0) ? CNT_W'(4) : CNT_W'(3);
        pay_bytes = wr_en ? CNT_W'(req_len) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_len <= '0;
        end else if (load) begin
            frame_len <= hdr_bytes + pay_bytes;
        end
    end

endmodule

// File: rtl/aux_fb_ctrl.sv
module aux_fb_ctrl
    import aux_fb_pkg::*;
#(
    parameter int MAX_LEN = 16,
    localparam int LEN_W = $clog2(MAX_LEN + 1),
    localparam int IDX_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [AUX_CMD_W-1:0]  cmd,
    input  logic [AUX_ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]      req_len,
    input  logic                  wr_en,
    input  logic                  dly_zero,
    input  logic                  dly_done,
    input  logic                  out_ready,
    input  logic [7:0]            pay_byte,
    output logic                  accept,
    output logic                  in_wait,
    output logic                  out_valid,
    output logic [7:0]            out_byte,
    output logic                  out_last,
    output logic [IDX_W-1:0]      pay_idx,
    output logic                  busy
);
    fb_state_e             state_q, state_d;
    logic [AUX_CMD_W-1:0]  cmd_q;
    logic [AUX_ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]      len_q;
    logic                  wr_q;
    logic [IDX_W-1:0]      idx_q;
    logic                  fire;
    logic                  pay_end;

    assign accept  = (state_q == ST_IDLE) && start;
    assign fire    = out_valid && out_ready;
    assign pay_end = (LEN_W'(idx_q) == len_q - LEN_W'(1));

    // State register and captured descriptor
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cmd_q   <= '0;
            addr_q  <= '0;
            len_q   <= '0;
            wr_q    <= 1'b0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cmd_q  <= cmd;
                addr_q <= addr;
                len_q  <= req_len;
                wr_q   <= wr_en;
                idx_q  <= '0;
            end else if (state_q == ST_DATA && fire) begin
                idx_q  <= idx_q + IDX_W'(1);
            end
        end
    end

    // Next state and stream outputs
    always_comb begin
        state_d   = state_q;
        out_valid = 1'b0;
        out_byte  = '0;
        out_last  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = dly_zero ? ST_HDR0 : ST_WAIT;
            end
            ST_WAIT: begin
                if (dly_done) state_d = ST_HDR0;
            end
            ST_HDR0: begin
                out_valid = 1'b1;
                out_byte  = {cmd_q, addr_q[19:16]};
                if (fire) state_d = ST_HDR1;
            end
            ST_HDR1: begin
                out_valid = 1'b1;
                out_byte  = addr_q[15:8];
                if (fire) state_d = ST_HDR2;
            end
            ST_HDR2: begin
                out_valid = 1'b1;
                out_byte  = addr_q[7:0];
                out_last  = (len_q == '0);
                if (fire) state_d = (len_q == '0) ? ST_IDLE : ST_LEN;
            end
            ST_LEN: begin
                out_valid = 1'b1;
                out_byte  = 8'(len_q - LEN_W'(1));
                out_last  = !wr_q;
                if (fire) state_d = wr_q ? ST_DATA : ST_IDLE;
            end
            ST_DATA: begin
                out_valid = 1'b1;
                out_byte  = pay_byte;
                out_last  = pay_end;
                if (fire && pay_end) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign in_wait = (state_q == ST_WAIT);
    assign busy    = (state_q != ST_IDLE);
    assign pay_idx = idx_q;

endmodule

// File: rtl/aux_req_framer.sv
module aux_req_framer
    import aux_fb_pkg::*;
#(
    parameter int MAX_LEN = 16,
    parameter int DLY_W   = 8,
    localparam int LEN_W = $clog2(MAX_LEN + 1),
    localparam int IDX_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1,
    localparam int CNT_W = $clog2(MAX_LEN + 5)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [AUX_CMD_W-1:0]  cmd,
    input  logic [AUX_ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]      req_len,
    input  logic                  wr_en,
    input  logic [DLY_W-1:0]      start_dly,
    output logic [IDX_W-1:0]      pay_idx,
    input  logic [7:0]            pay_byte,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [7:0]            out_byte,
    output logic                  out_last,
    output logic [CNT_W-1:0]      frame_len,
    output logic                  busy
);
    logic accept;
    logic in_wait;
    logic dly_done;
    logic dly_zero;

    assign dly_zero = (start_dly == '0);

    aux_fb_ctrl #(.MAX_LEN(MAX_LEN)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmd       (cmd),
        .addr      (addr),
        .req_len   (req_len),
        .wr_en     (wr_en),
        .dly_zero  (dly_zero),
        .dly_done  (dly_done),
        .out_ready (out_ready),
        .pay_byte  (pay_byte),
        .accept    (accept),
        .in_wait   (in_wait),
        .out_valid (out_valid),
        .out_byte  (out_byte),
        .out_last  (out_last),
        .pay_idx   (pay_idx),
        .busy      (busy)
    );

    aux_fb_delay #(.DLY_W(DLY_W)) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (start_dly),
        .run      (in_wait),
        .done     (dly_done)
    );

    aux_fb_count #(.MAX_LEN(MAX_LEN)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .req_len   (req_len),
        .wr_en     (wr_en),
        .frame_len (frame_len)
    );

endmodule

// File: rtl/aux_req_framer_chk.sv
module aux_req_framer_chk #(
    parameter int MAX_LEN = 16,
    localparam int CNT_W = $clog2(MAX_LEN + 5)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             out_valid,
    input logic             out_ready,
    input logic [7:0]       out_byte,
    input logic             out_last,
    input logic [CNT_W-1:0] frame_len
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !out_valid);

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_last)));

    // R11
    last_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R11
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(out_valid && out_ready && out_last));

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(frame_len));

    // R7
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_len <= CNT_W'(MAX_LEN + 4));

endmodule

bind aux_req_framer aux_req_framer_chk #(.MAX_LEN(MAX_LEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_byte  (out_byte),
    .out_last  (out_last),
    .frame_len (frame_len)
);

// File: tb/aux_req_framer_test.sv
module aux_req_framer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  cmd = '0;
    logic [19:0] addr = '0;
    logic [4:0]  req_len = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  start_dly = '0;
    logic [3:0]  pay_idx;
    logic [7:0]  pay_byte;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_byte;
    logic        out_last;
    logic [4:0]  frame_len;
    logic        busy;

    logic [7:0]  pay_mem [0:15];
    logic [7:0]  exp_b   [0:19];
    int          n_tests = 0;
    int          n_fail  = 0;
    bit          finished = 1'b0;

    always #4 clk = ~clk;

    assign pay_byte = pay_mem[pay_idx];

    aux_req_framer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmd       (cmd),
        .addr      (addr),
        .req_len   (req_len),
        .wr_en     (wr_en),
        .start_dly (start_dly),
        .pay_idx   (pay_idx),
        .pay_byte  (pay_byte),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_byte  (out_byte),
        .out_last  (out_last),
        .frame_len (frame_len),
        .busy      (busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    task automatic fill_payload(input logic [7:0] seed);
        for (int i = 0; i < 16; i++) pay_mem[i] = seed + 8'(i * 37);
    endtask

    // inj: 0 none, 1 start mid-frame, 2 start with the final handshake
    task automatic run_frame(input logic [3:0] c, input logic [19:0] a, input int len,
                             input bit wr, input int dly, input bit stall, input int inj);
        int n;
        int k;
        int waits;
        int cyc;
        int exp_len;
        bit prev_stall;
        logic [7:0] prev_byte;
        string tag;
        n = 3;
        exp_b[0] = {c, a[19:16]};
        exp_b[1] = a[15:8];
        exp_b[2] = a[7:0];
        if (len != 0) begin
            exp_b[3] = 8'(len - 1);
            n = 4;
            if (wr) for (int i = 0; i < len; i++) exp_b[4 + i] = pay_mem[i];
        end
        exp_len = ((len != 0) ? 4 : 3) + (wr ? len : 0);
        if (wr) n = exp_len;

        @(negedge clk);
        cmd = c; addr = a; req_len = 5'(len); wr_en = wr; start_dly = 8'(dly);
        start = 1'b1; out_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        cmd = ~c; addr = ~a; req_len = 5'd16; wr_en = ~wr; start_dly = 8'd3;
        check(frame_len == 5'(exp_len), "R7", frame_len, exp_len);
        waits = 1;
        while (!out_valid && waits < dly + 5) begin
            @(negedge clk);
            waits++;
        end
        check(waits == dly + 1, "R8", waits, dly + 1);

        k = 0; cyc = 0; prev_stall = 1'b0; prev_byte = '0;
        while (k < n && cyc < 200) begin
            out_ready = stall ? (cyc % 3 != 1) : 1'b1;
            start = 1'b0;
            if (inj == 1 && k == 1) begin
                start = 1'b1; cmd = 4'hF; addr = 20'hFFFFF; req_len = 5'd2;
            end
            if (inj == 2 && k == n - 1 && out_ready) start = 1'b1;
            if (out_valid) begin
                if (prev_stall)
                    check(out_byte == prev_byte, "R10", out_byte, prev_byte);
                if (out_ready) begin
                    if (k == 0) tag = "R2";
                    else if (k < 3) tag = "R3";
                    else if (k == 3) tag = "R4";
                    else tag = "R5";
                    check(out_byte == exp_b[k], tag, out_byte, exp_b[k]);
                    check(out_last == (k == n - 1), (!wr && len != 0) ? "R6" : "R11",
                          out_last, (k == n - 1));
                    k++;
                end
                prev_stall = !out_ready;
                prev_byte  = out_byte;
            end
            cyc++;
            @(negedge clk);
        end
        start = 1'b0;
        out_ready = 1'b1;
        check(k == n, "R11", k, n);
        check(!busy && !out_valid, (inj != 0) ? "R9" : "R11", {busy, out_valid}, 0);
        check(frame_len == 5'(exp_len), (inj != 0) ? "R9" : "R7", frame_len, exp_len);
        @(negedge clk);
        check(!out_valid, "R9", out_valid, 0);
    endtask

    task automatic t_reset;
        check(!out_valid && !out_last && !busy, "R1", {out_valid, out_last, busy}, 0);
        check(frame_len == 0, "R1", frame_len, 0);
    endtask

    task automatic t_read_no_len;  run_frame(4'h9, 20'hA_BC12, 0, 1'b0, 0, 1'b0, 0); endtask
    task automatic t_read_len;     run_frame(4'h9, 20'h0_0100, 16, 1'b0, 0, 1'b0, 0); endtask
    task automatic t_write_pay;    fill_payload(8'h11); run_frame(4'h8, 20'h5_4321, 5, 1'b1, 0, 1'b0, 0); endtask
    task automatic t_write_full;   fill_payload(8'hC3); run_frame(4'h0, 20'hF_0F0F, 16, 1'b1, 0, 1'b1, 0); endtask
    task automatic t_write_zero;   run_frame(4'h4, 20'h0_0050, 0, 1'b1, 0, 1'b0, 0); endtask
    task automatic t_delay;        run_frame(4'h1, 20'h1_2345, 1, 1'b0, 7, 1'b0, 0); endtask
    task automatic t_delay_one;    fill_payload(8'h5A); run_frame(4'h5, 20'h2_0000, 2, 1'b1, 1, 1'b1, 0); endtask
    task automatic t_busy_start;   fill_payload(8'h77); run_frame(4'h8, 20'h3_3333, 3, 1'b1, 2, 1'b1, 1); endtask
    task automatic t_last_collide; run_frame(4'h9, 20'h7_ABCD, 4, 1'b0, 0, 1'b0, 2); endtask

    initial begin
        fill_payload(8'h00);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_no_len();
        t_read_len();
        t_write_pay();
        t_write_full();
        t_write_zero();
        t_delay();
        t_delay_one();
        t_busy_start();
        t_last_collide();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule